// File: doc/BRIEF.md
# One-shot and Periodic Interval Timer

This block counts ticks of a prescaled time base against a programmed initial count and, when the count runs out, raises a one-cycle expiry event that carries an interrupt vector. The time base is a free-running time value supplied from outside. The block subtracts the time recorded at the last load and shifts the difference right by a programmable divide shift. A small table entry selects the vector, a mask and the mode (one-shot or periodic). The current remaining count can be read at any time.

In periodic mode, expiries fall on whole multiples of (initial count + 1) ticks, measured from the load time. After each expiry the next due tick is recomputed from the elapsed ticks at that moment. If several periods were skipped, they produce a single event, and the schedule lands on the next multiple. A zero initial count disables the timer in either mode. A one-shot timer stops for good once its count runs out, until the next load.

Top module: `interval_timer`

## Requirements
- R1: After reset, evt_fire and tmr_active are 0, cnt_now is 0, and the table entry is masked, one-shot, vector 0.
- R2: Elapsed ticks equal (now_time − load time) shifted right by the divide shift. Writing a new shift changes the tick rate without restarting the timer.
- R3: A write to the initial count records now_time as the load time and restarts the schedule. The timer is active after that write exactly when the value written is nonzero.
- R4: In one-shot mode (entry bit 9 = 0) with initial count N > 0, one event is raised when elapsed ticks reach N. The timer then goes inactive and raises no further events. N = 0 raises none.
- R5: In periodic mode (entry bit 9 = 1) with initial count N > 0, events occur when elapsed ticks reach k·(N+1) for k = 1, 2, …
- R6: In periodic mode an initial count of zero leaves the timer inactive, with no events.
- R7: When the mask (entry bit 8) is 1, the event is suppressed, but the schedule still advances. A periodic timer moves to its next multiple, and a one-shot timer stops.
- R8: An event is evt_fire high for one cycle after the clock edge at which the elapsed ticks reach the due tick. evt_vector then holds entry bits 7:0.
- R9: If elapsed ticks pass several periodic due ticks at once, a single event is raised. The next due tick is the next multiple of (N+1) above the elapsed ticks.
- R10: cnt_now reads N − (elapsed mod (N+1)) in periodic mode. In one-shot mode it reads N − elapsed, clamped at 0.
- R11: An initial-count write on the same edge at which an expiry is due takes priority: no event is raised and the schedule restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_time | input | TIME_W | Free-running time value |
| cfg_init_we | input | 1 | Write strobe for the initial count (restarts the timer) |
| cfg_init_val | input | CNT_W | Initial count to load |
| cfg_div_we | input | 1 | Write strobe for the divide shift |
| cfg_div_val | input | SH_W | Divide shift (right shift of elapsed time) |
| cfg_ent_we | input | 1 | Write strobe for the table entry |
| cfg_ent_val | input | 10 | Entry: bit 9 periodic, bit 8 mask, bits 7:0 vector |
| evt_fire | output | 1 | One-cycle expiry event to the vector dispatch logic |
| evt_vector | output | 8 | Vector of the last event |
| cnt_now | output | CNT_W | Current remaining count |
| tmr_active | output | 1 | Timer armed and awaiting an expiry |

## Verification
The assertions assume that now_time never moves backwards. They also assume it never runs more than 2^TIME_W units past the load time, so the subtraction and the due-tick comparison never wrap. The stimulus only ever raises now_time, by small steps or by one deliberate forward jump, and keeps every run well inside that range. The assertions also assume that configuration writes are single-cycle strobes. The bench drives them that way, and it drives every input only at the falling clock edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int VEC_W = 8;
  localparam int ENT_W = VEC_W + 2;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vec;
  } ent_t;

  localparam ent_t ENT_RST = '{periodic: 1'b0, masked: 1'b1, vec: '0};
endpackage

// File: rtl/ivt_cfg.sv
module ivt_cfg
  import ivt_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 16,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              init_we,
  input  logic [CNT_W-1:0]  init_val,
  input  logic              div_we,
  input  logic [SH_W-1:0]   div_val,
  input  logic              ent_we,
  input  logic [ENT_W-1:0]  ent_val,
  output logic [CNT_W-1:0]  init_q,
  output logic [TIME_W-1:0] load_q,
  output logic [SH_W-1:0]   shift_q,
  output ent_t              ent_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= '0;
      load_q  <= '0;
      shift_q <= '0;
      ent_q   <= ENT_RST;
    end else begin
      if (init_we) begin
        init_q <= init_val;
        load_q <= now_time;
      end
      if (div_we) shift_q <= div_val;
      if (ent_we) ent_q <= ent_t'(ent_val);
    end
  end
endmodule

// File: rtl/ivt_view.sv
module ivt_view #(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 16,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] load_q,
  input  logic [SH_W-1:0]   shift_q,
  input  logic [CNT_W-1:0]  init_q,
  input  logic              periodic,
  output logic [TIME_W-1:0] elapsed,
  output logic [CNT_W-1:0]  cnt_now
);
  localparam int NW = TIME_W + 1;

  function automatic logic [TIME_W-1:0] ticks_since(
      logic [TIME_W-1:0] now_v, logic [TIME_W-1:0] base, logic [SH_W-1:0] sh);
    logic [TIME_W-1:0] diff;
    diff = now_v - base;
    return diff >> sh;
  endfunction

  function automatic logic [CNT_W-1:0] left_count(
      logic [TIME_W-1:0] e, logic [CNT_W-1:0] ini, logic per);
    logic [NW-1:0] e_x, i_x, p, r;
    e_x = NW'(e);
    i_x = NW'(ini);
    p   = i_x + NW'(1);
    if (per) begin
      r = e_x % p;
      return CNT_W'(i_x - r);
    end else if (e_x >= i_x) begin
      return '0;
    end else begin
      return CNT_W'(i_x - e_x);
    end
  endfunction

  assign elapsed = ticks_since(now_time, load_q, shift_q);
  assign cnt_now = left_count(elapsed, init_q, periodic);

  // R10: a periodic count never exceeds the programmed initial count
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    periodic |-> cnt_now <= init_q);
endmodule

// File: rtl/ivt_sched.sv
module ivt_sched
  import ivt_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] elapsed,
  input  logic [CNT_W-1:0]  init_q,
  input  ent_t              ent_q,
  input  logic              load_evt,
  input  logic [CNT_W-1:0]  load_val,
  output logic              armed,
  output logic              fire,
  output logic              evt_fire,
  output logic [VEC_W-1:0]  evt_vector
);
  localparam int NW = TIME_W + 1;

  logic [NW-1:0] due_tick;
  logic [NW-1:0] el_x;
  logic          reached;

  function automatic logic [NW-1:0] first_due(logic [CNT_W-1:0] ini, logic per);
    return NW'(ini) + NW'(per);
  endfunction

  function automatic logic [NW-1:0] next_aligned(logic [TIME_W-1:0] e,
                                                 logic [CNT_W-1:0] ini);
    logic [NW-1:0] p, q;
    p = NW'(ini) + NW'(1);
    q = NW'(e) / p;
    return (q + NW'(1)) * p;
  endfunction

  assign el_x    = NW'(elapsed);
  assign reached = el_x >= due_tick;
  assign fire    = armed && reached && !load_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      due_tick   <= '0;
      evt_fire   <= 1'b0;
      evt_vector <= '0;
    end else begin
      evt_fire <= fire && !ent_q.masked;
      if (fire) evt_vector <= ent_q.vec;
      if (load_evt) begin
        armed    <= (load_val != '0);
        due_tick <= first_due(load_val, ent_q.periodic);
      end else if (fire) begin
        if (ent_q.periodic && init_q != '0) due_tick <= next_aligned(elapsed, init_q);
        else armed <= 1'b0;
      end
    end
  end

  // R3: a load arms the timer exactly when the loaded count is nonzero
  a_r3_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> armed == ($past(load_val) != '0));
  // R4: a one-shot expiry leaves the timer idle
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ent_q.periodic |=> !armed);
  // R5, R9: a periodic expiry moves the due tick strictly past the elapsed ticks
  a_r5_next_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ent_q.periodic && init_q != '0 |=> armed && due_tick > $past(el_x));
  // R8: an event only follows a cycle in which the timer was armed
  a_r8_event_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |-> $past(armed));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 16,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              cfg_init_we,
  input  logic [CNT_W-1:0]  cfg_init_val,
  input  logic              cfg_div_we,
  input  logic [SH_W-1:0]   cfg_div_val,
  input  logic              cfg_ent_we,
  input  logic [ENT_W-1:0]  cfg_ent_val,
  output logic              evt_fire,
  output logic [VEC_W-1:0]  evt_vector,
  output logic [CNT_W-1:0]  cnt_now,
  output logic              tmr_active
);
  logic [CNT_W-1:0]  init_q;
  logic [TIME_W-1:0] load_q;
  logic [SH_W-1:0]   shift_q;
  ent_t              ent_q;
  logic [TIME_W-1:0] elapsed;
  logic              fire;

  ivt_cfg #(.TIME_W(TIME_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .init_we(cfg_init_we), .init_val(cfg_init_val),
    .div_we(cfg_div_we), .div_val(cfg_div_val),
    .ent_we(cfg_ent_we), .ent_val(cfg_ent_val),
    .init_q(init_q), .load_q(load_q), .shift_q(shift_q), .ent_q(ent_q)
  );

  ivt_view #(.TIME_W(TIME_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_view (
    .clk(clk), .rst_n(rst_n), .now_time(now_time), .load_q(load_q),
    .shift_q(shift_q), .init_q(init_q), .periodic(ent_q.periodic),
    .elapsed(elapsed), .cnt_now(cnt_now)
  );

  ivt_sched #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .elapsed(elapsed), .init_q(init_q),
    .ent_q(ent_q), .load_evt(cfg_init_we), .load_val(cfg_init_val),
    .armed(tmr_active), .fire(fire), .evt_fire(evt_fire),
    .evt_vector(evt_vector)
  );

  // R11: no event follows an edge that carried a load
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init_we |=> !evt_fire);
  // R7: the event follows an internal expiry of an unmasked entry only
  a_r7_event_source: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |-> $past(fire) && !$past(ent_q.masked));
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] now_time = '0;
  logic        cfg_init_we = 1'b0;
  logic [15:0] cfg_init_val = '0;
  logic        cfg_div_we = 1'b0;
  logic [2:0]  cfg_div_val = '0;
  logic        cfg_ent_we = 1'b0;
  logic [9:0]  cfg_ent_val = '0;
  logic        evt_fire;
  logic [7:0]  evt_vector;
  logic [15:0] cnt_now;
  logic        tmr_active;

  int n_tot = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .cfg_init_we(cfg_init_we), .cfg_init_val(cfg_init_val),
    .cfg_div_we(cfg_div_we), .cfg_div_val(cfg_div_val),
    .cfg_ent_we(cfg_ent_we), .cfg_ent_val(cfg_ent_val),
    .evt_fire(evt_fire), .evt_vector(evt_vector),
    .cnt_now(cnt_now), .tmr_active(tmr_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] t);
    now_time = t;
    @(negedge clk);
  endtask

  task automatic wr_ent(input logic per, input logic msk, input logic [7:0] vec);
    cfg_ent_we = 1'b1;
    cfg_ent_val = {per, msk, vec};
    @(negedge clk);
    cfg_ent_we = 1'b0;
  endtask

  task automatic wr_div(input logic [2:0] s);
    cfg_div_we = 1'b1;
    cfg_div_val = s;
    @(negedge clk);
    cfg_div_we = 1'b0;
  endtask

  task automatic load(input logic [31:0] t, input logic [15:0] v);
    now_time = t;
    cfg_init_we = 1'b1;
    cfg_init_val = v;
    @(negedge clk);
    cfg_init_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 evt_fire", 32'(evt_fire), 0);
    check("R1 tmr_active", 32'(tmr_active), 0);
    check("R1 cnt_now", 32'(cnt_now), 0);
    // default entry is masked: an armed one-shot expires silently
    load(10, 2);
    cyc(12);
    check("R1 masked default", 32'(evt_fire), 0);
    check("R1 one-shot default stops", 32'(tmr_active), 0);
  endtask

  task automatic t_oneshot();
    wr_div(0);
    wr_ent(0, 0, 8'h31);
    load(100, 5);
    check("R3 armed after load", 32'(tmr_active), 1);
    check("R10 one-shot count at load", 32'(cnt_now), 5);
    cyc(104);
    check("R4 no early event", 32'(evt_fire), 0);
    check("R10 one-shot count", 32'(cnt_now), 1);
    cyc(105);
    check("R4 event at N", 32'(evt_fire), 1);
    check("R8 vector", 32'(evt_vector), 32'h31);
    check("R10 one-shot clamp", 32'(cnt_now), 0);
    cyc(106);
    check("R8 single cycle", 32'(evt_fire), 0);
    check("R4 stopped", 32'(tmr_active), 0);
    cyc(130);
    check("R4 no further event", 32'(evt_fire), 0);
    load(200, 0);
    check("R4 zero one-shot inactive", 32'(tmr_active), 0);
    cyc(260);
    check("R4 zero one-shot silent", 32'(evt_fire), 0);
  endtask

  task automatic t_periodic();
    wr_div(1);
    wr_ent(1, 0, 8'h42);
    load(1000, 3);
    cyc(1006);
    check("R10 periodic count e=3", 32'(cnt_now), 0);
    check("R5 no event before N+1", 32'(evt_fire), 0);
    cyc(1007);
    check("R2 shifted ticks no event", 32'(evt_fire), 0);
    cyc(1008);
    check("R5 first event", 32'(evt_fire), 1);
    check("R8 periodic vector", 32'(evt_vector), 32'h42);
    check("R10 periodic count e=4", 32'(cnt_now), 3);
    cyc(1010);
    check("R10 periodic count e=5", 32'(cnt_now), 2);
    cyc(1015);
    check("R5 no event mid period", 32'(evt_fire), 0);
    cyc(1016);
    check("R5 second event", 32'(evt_fire), 1);
    cyc(1040);
    check("R9 coalesced event", 32'(evt_fire), 1);
    cyc(1041);
    check("R9 only one event", 32'(evt_fire), 0);
    cyc(1047);
    check("R9 aligned not early", 32'(evt_fire), 0);
    cyc(1048);
    check("R9 aligned event", 32'(evt_fire), 1);
  endtask

  task automatic t_periodic_zero();
    load(1100, 0);
    check("R6 inactive", 32'(tmr_active), 0);
    cyc(1200);
    check("R6 no event", 32'(evt_fire), 0);
    check("R6 count zero", 32'(cnt_now), 0);
  endtask

  task automatic t_mask();
    wr_div(0);
    wr_ent(1, 1, 8'h55);
    load(2000, 2);
    cyc(2003);
    check("R7 masked expiry silent", 32'(evt_fire), 0);
    wr_ent(1, 0, 8'h55);
    check("R7 no event on unmask", 32'(evt_fire), 0);
    cyc(2004);
    check("R7 schedule advanced (2004)", 32'(evt_fire), 0);
    cyc(2005);
    check("R7 schedule advanced (2005)", 32'(evt_fire), 0);
    cyc(2006);
    check("R7 next multiple fires", 32'(evt_fire), 1);
    check("R7 vector", 32'(evt_vector), 32'h55);
    wr_ent(0, 1, 8'h56);
    load(2100, 2);
    cyc(2102);
    check("R7 masked one-shot silent", 32'(evt_fire), 0);
    check("R7 masked one-shot stops", 32'(tmr_active), 0);
  endtask

  task automatic t_shift();
    wr_ent(0, 0, 8'h60);
    load(3000, 10);
    cyc(3004);
    check("R2 count before shift", 32'(cnt_now), 6);
    wr_div(2);
    check("R2 still armed", 32'(tmr_active), 1);
    check("R2 count after shift", 32'(cnt_now), 9);
    cyc(3039);
    check("R2 no early event", 32'(evt_fire), 0);
    check("R2 count e=9", 32'(cnt_now), 1);
    cyc(3040);
    check("R2 event at scaled tick", 32'(evt_fire), 1);
  endtask

  task automatic t_collide();
    wr_div(0);
    wr_ent(1, 0, 8'h70);
    load(4000, 1);
    cyc(4001);
    check("R5 no event at e=1", 32'(evt_fire), 0);
    load(4002, 5);
    check("R11 load wins", 32'(evt_fire), 0);
    check("R11 restarted armed", 32'(tmr_active), 1);
    cyc(4007);
    check("R11 new period not early", 32'(evt_fire), 0);
    cyc(4008);
    check("R11 new period fires", 32'(evt_fire), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_periodic();
    t_periodic_zero();
    t_mask();
    t_shift();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule